// File: doc/BRIEF.md
# Serial Flash Power-Mode Front End

This block sits behind the slave pins of a serial flash and looks after its power modes. While chip select is low it collects an 8-bit opcode, most significant bit first, from the serial data input. It watches for two opcodes. The first is a sleep request. The block honours it only when chip select goes high exactly on the byte boundary and the program/erase engine is idle. After a fixed settling delay the block is then in its lowest-power mode. The second is a wake-and-identify opcode. It brings the block back to Standby and streams an identification byte out on the serial data output.

Chip select, serial clock and serial data are sampled into the system clock domain through a synchronizer chain, and edges are detected there. The settling delay is counted in system clock cycles. While asleep or settling, the block withholds the gate that lets write, program and erase commands reach the array. The array itself lies outside this block.

Top module: `spi_pm_ctrl`

## Requirements
- R1: After reset `pwr_state` is 2'b00 (Standby), `wr_gate` is 1 and `sdo` is 0. The state codes are 2'b00 Standby, 2'b01 settling and 2'b10 asleep.
- R2: A sleep opcode (8'hB9) that is accepted moves `pwr_state` to 2'b01 one cycle after the synchronized chip-select rise is seen. It holds 2'b01 for exactly TDP_CYC system cycles and then reads 2'b10.
- R3: A sleep opcode is acted on only if exactly 8 serial clock rising edges came before chip select went high. With 7 or 9 edges the block stays in Standby.
- R4: If `busy` is high in the cycle the chip-select rise is evaluated, the sleep opcode is discarded and the block stays in Standby. `busy` falling in that same cycle lets the opcode through.
- R5: `wr_gate` is 0 whenever `pwr_state` is not 2'b00.
- R6: While asleep, every opcode except 8'hAB leaves `pwr_state` at 2'b10 and `wr_gate` at 0, and `sdo` stays 0 for the rest of that frame.
- R7: While asleep, opcode 8'hAB returns `pwr_state` to 2'b00 within the same frame, once its eighth bit has been taken in. `wr_gate` returns to 1.
- R8: After opcode 8'hAB, received in Standby or while asleep, `sdo` changes on serial clock falling edges. Its first 24 bits are 0. After that the identification byte SIG (default 8'h13) repeats, MSB first, for as long as the frame lasts.
- R9: `sdo` is 0 while chip select is high. Each new frame restarts the output sequence from its first dummy bit.
- R10: In Standby, opcodes other than 8'hB9 leave `pwr_state` at 2'b00 and `wr_gate` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| busy | input | 1 | Program/erase engine busy flag, system clock domain |
| sdo | output | 1 | Serial data out |
| pwr_state | output | 2 | Power state: 00 Standby, 01 settling, 10 asleep |
| wr_gate | output | 1 | High when write, program and erase commands may proceed |

## Verification
The sleep decision reads `busy` in the one cycle where the synchronized chip-select rise is evaluated. A change of the busy flag can land in that exact cycle. The bench counts the synchronizer stages from its own drive of chip select to place that cycle. In one frame it raises `busy` there, and in another frame it drops `busy` there. It then judges the outcome from `pwr_state`: in the first case the block must stay in Standby, and in the second it must settle for exactly TDP_CYC cycles before reporting asleep.

// File: rtl/spi_pm_pkg.sv
`timescale 1ns/1ps
package spi_pm_pkg;
   typedef enum logic [1:0] {
      PM_STANDBY = 2'b00,
      PM_PENDING = 2'b01,
      PM_DEEP    = 2'b10
   } pm_state_e;
endpackage

// File: rtl/spi_pm_sync.sv
`timescale 1ns/1ps
// Multi-bit flop chain bringing asynchronous pins into the clk domain
module spi_pm_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pm_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_pm_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_pm_rx.sv
`timescale 1ns/1ps
// Opcode collector: counts serial clock rises per frame, captures first byte
module spi_pm_rx #(
   parameter int OP_W  = 8,
   parameter int CNT_W = $clog2(OP_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             sclk_rise,
   input  logic             sdi_s,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [OP_W-1:0]  opc_q,
   output logic [OP_W-1:0]  opc_now,
   output logic             opc_valid
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_W - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(OP_W + 1);

   if (OP_W < 2) begin : g_bad_opw
      $error("spi_pm_rx: OP_W must be at least 2");
   end

   logic [OP_W-2:0] sh;

   assign opc_now   = {sh, sdi_s};
   assign opc_valid = sclk_rise && !cs_s && (bit_cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bit_cnt <= '0;
         opc_q   <= '0;
      end else if (cs_s) begin
         bit_cnt <= '0;
      end else if (sclk_rise) begin
         sh <= opc_now[OP_W-2:0];
         if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + CNT_W'(1);
         if (bit_cnt == CNT_LAST) opc_q <= opc_now;
      end
   end
endmodule

// File: rtl/spi_pm_fsm.sv
`timescale 1ns/1ps
// Power-state machine with settling-delay counter
module spi_pm_fsm
   import spi_pm_pkg::*;
#(
   parameter int              OP_W    = 8,
   parameter int              CNT_W   = $clog2(OP_W + 2),
   parameter int              TDP_CYC = 40,
   parameter logic [OP_W-1:0] OPC_DP  = 8'hB9,
   parameter logic [OP_W-1:0] OPC_RES = 8'hAB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_rise,
   input  logic [CNT_W-1:0] bit_cnt,
   input  logic [OP_W-1:0]  opc_q,
   input  logic [OP_W-1:0]  opc_now,
   input  logic             opc_valid,
   input  logic             busy,
   output pm_state_e        state,
   output logic             wr_gate,
   output logic             sig_start
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_W);

   if (TDP_CYC < 1) begin : g_bad_tdp
      $error("spi_pm_fsm: TDP_CYC must be at least 1");
   end

   pm_state_e nxt;
   logic      tdp_done;
   logic      dp_ok;
   logic      res_hit;

   assign dp_ok     = cs_rise && (bit_cnt == CNT_FULL) && (opc_q == OPC_DP) && !busy;
   assign res_hit   = opc_valid && (opc_now == OPC_RES);
   assign sig_start = res_hit && (state != PM_PENDING);

   if (TDP_CYC == 1) begin : g_tdp_short
      assign tdp_done = 1'b1;
   end else begin : g_tdp_count
      localparam int TW = $clog2(TDP_CYC);
      localparam logic [TW-1:0] T_LAST = TW'(TDP_CYC - 1);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   tcnt <= '0;
         else if (state == PM_PENDING) tcnt <= tcnt + TW'(1);
         else                          tcnt <= '0;
      end
      assign tdp_done = (tcnt == T_LAST);
   end

   always_comb begin
      nxt = state;
      unique case (state)
         PM_STANDBY: if (dp_ok)    nxt = PM_PENDING;
         PM_PENDING: if (tdp_done) nxt = PM_DEEP;
         PM_DEEP:    if (res_hit)  nxt = PM_STANDBY;
         default:                  nxt = PM_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PM_STANDBY;
         wr_gate <= 1'b1;
      end else begin
         state   <= nxt;
         wr_gate <= (nxt == PM_STANDBY);
      end
   end
endmodule

// File: rtl/spi_pm_tx.sv
`timescale 1ns/1ps
// Identification serializer: dummy bits then a rotating signature byte
module spi_pm_tx #(
   parameter int              OP_W        = 8,
   parameter int              DUMMY_BYTES = 3,
   parameter logic [OP_W-1:0] SIG         = 8'h13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic sclk_fall,
   input  logic sig_start,
   output logic sdo
);
   localparam int DUMMY_BITS = DUMMY_BYTES * OP_W;

   if (DUMMY_BYTES < 0) begin : g_bad_dummy
      $error("spi_pm_tx: DUMMY_BYTES must not be negative");
   end

   logic            active;
   logic            dummy_done;
   logic [OP_W-1:0] sig_sh;

   if (DUMMY_BYTES == 0) begin : g_no_dummy
      assign dummy_done = 1'b1;
   end else begin : g_dummy
      localparam int DW = $clog2(DUMMY_BITS + 1);
      localparam logic [DW-1:0] D_END = DW'(DUMMY_BITS);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  dcnt <= '0;
         else if (cs_s || sig_start)                  dcnt <= '0;
         else if (active && sclk_fall && !dummy_done) dcnt <= dcnt + DW'(1);
      end
      assign dummy_done = (dcnt == D_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sdo    <= 1'b0;
         sig_sh <= SIG;
      end else if (cs_s) begin
         active <= 1'b0;
         sdo    <= 1'b0;
      end else if (sig_start) begin
         active <= 1'b1;
         sdo    <= 1'b0;
         sig_sh <= SIG;
      end else if (active && sclk_fall) begin
         if (!dummy_done) begin
            sdo <= 1'b0;
         end else begin
            sdo    <= sig_sh[OP_W-1];
            sig_sh <= {sig_sh[OP_W-2:0], sig_sh[OP_W-1]};
         end
      end
   end
endmodule

// File: rtl/spi_pm_ctrl.sv
`timescale 1ns/1ps
// Top: serial flash power-mode front end
module spi_pm_ctrl
   import spi_pm_pkg::*;
#(
   parameter int              OP_W        = 8,
   parameter int              TDP_CYC     = 40,
   parameter int              SYNC_STAGES = 2,
   parameter int              DUMMY_BYTES = 3,
   parameter logic [OP_W-1:0] SIG         = 8'h13,
   parameter logic [OP_W-1:0] OPC_DP      = 8'hB9,
   parameter logic [OP_W-1:0] OPC_RES     = 8'hAB
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   input  logic       busy,
   output logic       sdo,
   output logic [1:0] pwr_state,
   output logic       wr_gate
);
   localparam int CNT_W = $clog2(OP_W + 2);

   if (OP_W < 2) begin : g_bad_opw
      $error("spi_pm_ctrl: OP_W must be at least 2");
   end
   if (OPC_DP == OPC_RES) begin : g_bad_opc
      $error("spi_pm_ctrl: sleep and wake opcodes must differ");
   end

   logic cs_s, sclk_s, sdi_s;
   logic cs_d, sclk_d;
   logic cs_rise, sclk_rise, sclk_fall;

   spi_pm_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_s, sclk_s, sdi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   assign cs_rise   = cs_s & ~cs_d;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   logic [CNT_W-1:0] bit_cnt;
   logic [OP_W-1:0]  opc_q, opc_now;
   logic             opc_valid;
   logic             sig_start;
   pm_state_e        state;

   spi_pm_rx #(
      .OP_W  (OP_W),
      .CNT_W (CNT_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sclk_rise (sclk_rise),
      .sdi_s     (sdi_s),
      .bit_cnt   (bit_cnt),
      .opc_q     (opc_q),
      .opc_now   (opc_now),
      .opc_valid (opc_valid)
   );

   spi_pm_fsm #(
      .OP_W    (OP_W),
      .CNT_W   (CNT_W),
      .TDP_CYC (TDP_CYC),
      .OPC_DP  (OPC_DP),
      .OPC_RES (OPC_RES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_rise   (cs_rise),
      .bit_cnt   (bit_cnt),
      .opc_q     (opc_q),
      .opc_now   (opc_now),
      .opc_valid (opc_valid),
      .busy      (busy),
      .state     (state),
      .wr_gate   (wr_gate),
      .sig_start (sig_start)
   );

   spi_pm_tx #(
      .OP_W        (OP_W),
      .DUMMY_BYTES (DUMMY_BYTES),
      .SIG         (SIG)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sclk_fall (sclk_fall),
      .sig_start (sig_start),
      .sdo       (sdo)
   );

   assign pwr_state = state;
endmodule

// File: rtl/spi_pm_ctrl_chk.sv
`timescale 1ns/1ps
module spi_pm_ctrl_chk #(
   parameter int              OP_W    = 8,
   parameter int              CNT_W   = 4,
   parameter logic [OP_W-1:0] OPC_RES = 8'hAB
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             cs_s,
   input logic             cs_rise,
   input logic             opc_valid,
   input logic [OP_W-1:0]  opc_now,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [1:0]       pwr_state,
   input logic             wr_gate,
   input logic             sdo
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(OP_W);

   // R2
   deep_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b10 && $past(pwr_state) != 2'b10) |-> $past(pwr_state) == 2'b01);

   // R3
   pend_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b01 && $past(pwr_state) == 2'b00) |-> ($past(cs_rise) && $past(bit_cnt) == FULL));

   // R4
   pend_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b01 && $past(pwr_state) == 2'b00) |-> !$past(busy));

   // R5
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 2'b00) |-> !wr_gate);

   // R7
   wake_only_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == 2'b10 && pwr_state != 2'b10) |->
      (pwr_state == 2'b00 && $past(opc_valid) && $past(opc_now) == OPC_RES));

   // R9
   idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !sdo);
endmodule

bind spi_pm_ctrl spi_pm_ctrl_chk #(
   .OP_W    (OP_W),
   .CNT_W   (CNT_W),
   .OPC_RES (OPC_RES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .cs_s      (cs_s),
   .cs_rise   (cs_rise),
   .opc_valid (opc_valid),
   .opc_now   (opc_now),
   .bit_cnt   (bit_cnt),
   .pwr_state (pwr_state),
   .wr_gate   (wr_gate),
   .sdo       (sdo)
);

// File: tb/spi_pm_ctrl_tb.sv
`timescale 1ns/1ps
module spi_pm_ctrl_tb;
   localparam int       TDP = 20;
   localparam bit [7:0] SIG = 8'h13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, busy = 1'b0;
   logic sdo, wr_gate;
   logic [1:0] pwr_state;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   string mon_req = "R8";
   bit exp_q[$];

   always #2 clk = ~clk;

   spi_pm_ctrl #(.TDP_CYC(TDP), .SIG(SIG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .busy(busy), .sdo(sdo), .pwr_state(pwr_state), .wr_gate(wr_gate)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit exp_bit(input int k);
      if (k < 24) return 1'b0;
      return SIG[7 - ((k - 24) % 8)];
   endfunction

   // Monitor: compare each output bit at the serial clock rise
   always @(posedge sclk) begin
      if (mon_on) begin
         if (exp_q.size() == 0) chk({mon_req, " queue underrun"}, 1, 0);
         else chk(mon_req, int'(sdo), int'(exp_q.pop_front()));
      end
   end

   // Driver: mode 0 no output check, 1 signature expected, 2 zeros expected
   task automatic xfer(input logic [7:0] op, input int nop, input int nextra,
                       input int mode, input bit raise);
      cs_n = 1'b0;
      wait_n(4);
      for (int i = 0; i < nop + nextra; i++) begin
         if (i == nop && mode != 0) begin
            for (int k = 0; k < nextra; k++)
               exp_q.push_back(mode == 1 ? exp_bit(k) : 1'b0);
            mon_req = (mode == 1) ? "R8" : "R6";
            mon_on = 1'b1;
         end
         sdi = (i < nop && i < 8) ? op[7 - i] : 1'b0;
         wait_n(4); sclk = 1'b1;
         wait_n(8); sclk = 1'b0;
         wait_n(4);
      end
      mon_on = 1'b0;
      sdi = 1'b0;
      if (raise) begin
         wait_n(2);
         cs_n = 1'b1;
         wait_n(12);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int pend;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      // R1 reset state
      chk("R1 state", int'(pwr_state), 0);
      chk("R1 gate", int'(wr_gate), 1);
      chk("R1 sdo", int'(sdo), 0);

      // R8 signature from Standby, R9 idle output after the frame
      xfer(8'hAB, 8, 40, 1, 1);
      chk("R9 sdo idle", int'(sdo), 0);
      chk("R10 state after AB", int'(pwr_state), 0);

      // R9 frame cut short, then full restart from the first dummy bit
      xfer(8'hAB, 8, 29, 1, 1);
      chk("R9 sdo after cut", int'(sdo), 0);
      xfer(8'hAB, 8, 34, 1, 1);

      // R10 other opcode in Standby
      xfer(8'h06, 8, 0, 0, 1);
      chk("R10 state", int'(pwr_state), 0);
      chk("R10 gate", int'(wr_gate), 1);

      // R3 wrong bit counts
      xfer(8'hB9, 7, 0, 0, 1);
      wait_n(TDP + 5);
      chk("R3 seven bits", int'(pwr_state), 0);
      xfer(8'hB9, 9, 0, 0, 1);
      wait_n(TDP + 5);
      chk("R3 nine bits", int'(pwr_state), 0);

      // R4 busy held through the frame
      busy = 1'b1;
      xfer(8'hB9, 8, 0, 0, 1);
      wait_n(TDP + 5);
      chk("R4 busy held", int'(pwr_state), 0);
      busy = 1'b0;

      // R4 busy rising in the decision cycle
      xfer(8'hB9, 8, 0, 0, 0);
      cs_n = 1'b1;
      wait_n(2);
      busy = 1'b1;
      wait_n(TDP + 5);
      chk("R4 busy rises at decision", int'(pwr_state), 0);
      chk("R4 gate", int'(wr_gate), 1);

      // R2 accepted with busy falling in the decision cycle
      xfer(8'hB9, 8, 0, 0, 0);
      cs_n = 1'b1;
      pend = 0;
      for (int i = 0; i < TDP * 4; i++) begin
         @(negedge clk);
         if (i == 1) busy = 1'b0;
         if (pwr_state == 2'b01) begin
            pend++;
            chk("R5 gate while settling", int'(wr_gate), 0);
         end
         if (pwr_state == 2'b10) break;
      end
      chk("R2 settle cycles", pend, TDP);
      chk("R2 asleep", int'(pwr_state), 2);
      chk("R5 gate asleep", int'(wr_gate), 0);

      // R6 ignored opcodes while asleep
      xfer(8'h06, 8, 0, 0, 1);
      chk("R6 state", int'(pwr_state), 2);
      chk("R6 gate", int'(wr_gate), 0);
      xfer(8'h03, 8, 16, 2, 1);
      chk("R6 state read", int'(pwr_state), 2);
      xfer(8'hB9, 8, 0, 0, 1);
      chk("R6 state sleep again", int'(pwr_state), 2);

      // R7 wake inside the frame, R8 signature while waking
      xfer(8'hAB, 8, 0, 0, 0);
      wait_n(8);
      chk("R7 state in frame", int'(pwr_state), 0);
      chk("R7 gate", int'(wr_gate), 1);
      cs_n = 1'b1;
      wait_n(12);
      xfer(8'hB9, 8, 0, 0, 1);
      wait_n(TDP + 5);
      chk("R2 asleep again", int'(pwr_state), 2);
      xfer(8'hAB, 8, 40, 1, 1);
      chk("R7 state after wake", int'(pwr_state), 0);
      chk("R8 queue drained", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule